// File: doc/BRIEF.md
# Per-Process Paging MMU with Supervisor Address Decode

This block sits between a 16-bit CPU and its memory. For every bus cycle it splits the logical address into a 4K page number (the top four bits) and a 12-bit offset. It then looks up a physical page number in a pagetable. The pagetable is indexed by the current process ID, the access direction and the logical page. Because the read and write mappings of a page are separate entries, a page can be mapped read-only, or a write can be steered to a different frame than a read. Several logical pages may name the same physical frame.

The same block decodes the privileged memory map. In user mode the whole 64K is paged. In supervisor mode the lower half is paged. The upper half holds a small I/O window, private kernel RAM and the pagetable itself. The pagetable fills the first 1K of every 4K block, so it is split into eight segments. A boot ROM overlays upper-half reads until a ROM-disable input is raised. Writes to the upper half always reach the private RAM or the pagetable, including while the ROM is mapped. The pagetable is held in an internal inferred RAM with one read port. A translation lookup and a direct pagetable access never fall in the same cycle, so the two share that port.

Top module: `mmu_pager`

## Requirements
- R1: When the paged-RAM select is active, `phys_page` is the 8-bit pagetable entry for the access and `page_off` equals address bits 11:0 unchanged.
- R2: A translation uses the entry at index {pid, rwb, address[15:12]}, where rwb=1 means read. A read and a write to the same logical page of the same process can therefore give different physical pages.
- R3: With `cpu_super` low, every address asserts `ram_cs` and no other select.
- R4: With `cpu_super` high, addresses 0x0000 to 0x7FFF assert `ram_cs`.
- R5: With `cpu_super` high, addresses 0x8400 to 0x87FF assert `io_cs`, for reads and writes, whatever the ROM state.
- R6: The pagetable region is a supervisor access in 0x8000 to 0xFFFF with address bits 11:10 equal to 0, excluding reads while the ROM is mapped. A read there asserts `pt_rd` and returns the entry on `pt_rdata`. A write there asserts `pt_wr` and stores `cpu_wdata` at the clock edge. Both use the index {pid, address[4], address[3:0]}, and all other address bits are ignored.
- R7: Any other supervisor upper-half access, outside the I/O window, the pagetable region and ROM reads, asserts `priv_cs`.
- R8: While the registered ROM-disable is low, supervisor reads in the upper half (outside the I/O window) assert `rom_cs`. Writes there still go to the pagetable or the private RAM.
- R9: `rom_dis_in` is registered. A change becomes visible on the selects in the cycle after the clock edge that samples it. Reset clears the register, so the block starts with the ROM mapped.
- R10: Exactly one of `ram_cs`, `io_cs`, `rom_cs`, `priv_cs`, `pt_rd`, `pt_wr` is active in every cycle.
- R11: Two logical pages whose entries hold the same value translate to the same physical page.
- R12: `phys_page` is zero whenever `ram_cs` is low, and `pt_rdata` is zero whenever `pt_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Logical address |
| cpu_rwb | input | 1 | 1 = read, 0 = write |
| cpu_super | input | 1 | 1 = supervisor mode |
| pid | input | PID_W | Current process ID |
| rom_dis_in | input | 1 | 1 = unmap the boot ROM |
| cpu_wdata | input | PPN_W | Write data for pagetable stores |
| ram_cs | output | 1 | Paged RAM select |
| io_cs | output | 1 | I/O window select |
| rom_cs | output | 1 | Boot ROM select |
| priv_cs | output | 1 | Private kernel RAM select |
| pt_rd | output | 1 | Pagetable read strobe |
| pt_wr | output | 1 | Pagetable write strobe |
| phys_page | output | PPN_W | Physical page number |
| page_off | output | 12 | Offset within the page |
| pt_rdata | output | PPN_W | Pagetable entry read by the CPU |

## Verification
A corrupted pagetable entry or a wrong index shows as a wrong `phys_page` in the same cycle as the access. A stored value is therefore checked on the first translation or direct read after the edge that wrote it. A stale ROM-disable register shows one cycle after its input changes, as `rom_cs` versus `pt_rd` or `priv_cs` on an upper-half read. A decode fault shows at once as the wrong select, or as more than one select. Random accesses across both modes are compared with a reference model of the pagetable. The I/O window edges, the segment gaps, aliasing and read-only mapping are driven directly.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int ADDR_BITS = 16;
    localparam int PAGE_BITS = 4;
    localparam int OFF_BITS  = ADDR_BITS - PAGE_BITS;

    // upper-half region codes, address bits 14:10 within 0x8000..0xFFFF
    localparam logic [4:0] IO_WINDOW = 5'b00001;

    typedef enum logic [2:0] {
        RGN_PAGED,
        RGN_IO,
        RGN_ROM,
        RGN_PRIV,
        RGN_PTAB
    } region_e;

    typedef struct packed {
        logic ram;
        logic io;
        logic rom;
        logic priv;
        logic ptrd;
        logic ptwr;
    } sel_t;

    function automatic sel_t region_to_sel(region_e r, logic rwb);
        sel_t s;
        s = '0;
        unique case (r)
            RGN_PAGED: s.ram  = 1'b1;
            RGN_IO:    s.io   = 1'b1;
            RGN_ROM:   s.rom  = 1'b1;
            RGN_PRIV:  s.priv = 1'b1;
            default: begin
                s.ptrd = rwb;
                s.ptwr = ~rwb;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mmu_romctl.sv
module mmu_romctl (
    input  logic clk,
    input  logic rst,
    input  logic rom_dis_in,
    output logic rom_dis_q
);
    always_ff @(posedge clk) begin
        if (rst) rom_dis_q <= 1'b0;
        else     rom_dis_q <= rom_dis_in;
    end
endmodule

// File: rtl/mmu_decode.sv
module mmu_decode
    import mmu_pkg::*;
(
    input  logic [5:0] addr_hi,   // address bits 15:10
    input  logic       rwb,
    input  logic       super_mode,
    input  logic       rom_dis,
    output region_e    region,
    output sel_t       sel
);
    always_comb begin
        if (!super_mode || !addr_hi[5])
            region = RGN_PAGED;
        else if (addr_hi[4:0] == IO_WINDOW)
            region = RGN_IO;
        else if (rwb && !rom_dis)
            region = RGN_ROM;
        else if (addr_hi[1:0] == 2'b00)
            region = RGN_PTAB;
        else
            region = RGN_PRIV;
    end

    assign sel = region_to_sel(region, rwb);
endmodule

// File: rtl/mmu_ptable.sv
module mmu_ptable #(
    parameter int IDX_W = 11,
    parameter int PPN_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [PPN_W-1:0] wdata,
    output logic [PPN_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [PPN_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/mmu_pager.sv
module mmu_pager
    import mmu_pkg::*;
#(
    parameter int PID_W = 6,
    parameter int PPN_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         cpu_addr,
    input  logic                cpu_rwb,
    input  logic                cpu_super,
    input  logic [PID_W-1:0]    pid,
    input  logic                rom_dis_in,
    input  logic [PPN_W-1:0]    cpu_wdata,
    output logic                ram_cs,
    output logic                io_cs,
    output logic                rom_cs,
    output logic                priv_cs,
    output logic                pt_rd,
    output logic                pt_wr,
    output logic [PPN_W-1:0]    phys_page,
    output logic [OFF_BITS-1:0] page_off,
    output logic [PPN_W-1:0]    pt_rdata
);
    localparam int IDX_W = PID_W + 1 + PAGE_BITS;

    logic             rom_dis_q;
    region_e          region;
    sel_t             sel;
    logic [IDX_W-1:0] xlat_idx;
    logic [IDX_W-1:0] direct_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [PPN_W-1:0] entry;

    mmu_romctl u_romctl (
        .clk        (clk),
        .rst        (rst),
        .rom_dis_in (rom_dis_in),
        .rom_dis_q  (rom_dis_q)
    );

    mmu_decode u_decode (
        .addr_hi    (cpu_addr[15:10]),
        .rwb        (cpu_rwb),
        .super_mode (cpu_super),
        .rom_dis    (rom_dis_q),
        .region     (region),
        .sel        (sel)
    );

    // translation index: process, direction, logical page
    assign xlat_idx   = {pid, cpu_rwb, cpu_addr[15:12]};
    // direct access index: process, direction bit A4, page in A3:A0
    assign direct_idx = {pid, cpu_addr[4:0]};
    // the single read port is shared: both never happen in one cycle
    assign tbl_idx    = (region == RGN_PTAB) ? direct_idx : xlat_idx;

    mmu_ptable #(.IDX_W(IDX_W), .PPN_W(PPN_W)) u_ptable (
        .clk   (clk),
        .we    (sel.ptwr),
        .idx   (tbl_idx),
        .wdata (cpu_wdata),
        .rdata (entry)
    );

    assign ram_cs    = sel.ram;
    assign io_cs     = sel.io;
    assign rom_cs    = sel.rom;
    assign priv_cs   = sel.priv;
    assign pt_rd     = sel.ptrd;
    assign pt_wr     = sel.ptwr;
    assign phys_page = sel.ram  ? entry : '0;
    assign pt_rdata  = sel.ptrd ? entry : '0;
    assign page_off  = cpu_addr[OFF_BITS-1:0];
endmodule

// File: rtl/mmu_pager_chk.sv
module mmu_pager_chk #(
    parameter int PPN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [5:0]       addr_hi,
    input logic             cpu_rwb,
    input logic             cpu_super,
    input logic             rom_dis_in,
    input logic             ram_cs,
    input logic             io_cs,
    input logic             rom_cs,
    input logic             priv_cs,
    input logic             pt_rd,
    input logic             pt_wr,
    input logic [PPN_W-1:0] phys_page
);
    // R10
    one_select_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({ram_cs, io_cs, rom_cs, priv_cs, pt_rd, pt_wr}) == 1);

    // R3
    user_paged_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_super |-> ram_cs);

    // R5
    io_window_chk: assert property (@(posedge clk) disable iff (rst)
        io_cs |-> (cpu_super && addr_hi == 6'b100001));

    // R6
    pt_write_chk: assert property (@(posedge clk) disable iff (rst)
        pt_wr |-> (!cpu_rwb && cpu_super && addr_hi[5] && addr_hi[1:0] == 2'b00));

    // R8
    rom_read_chk: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> cpu_rwb);

    // R9
    rom_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rom_dis_in)) |-> !rom_cs);

    // R12
    phys_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_cs |-> phys_page == '0);
endmodule

bind mmu_pager mmu_pager_chk #(.PPN_W(PPN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_hi    (cpu_addr[15:10]),
    .cpu_rwb    (cpu_rwb),
    .cpu_super  (cpu_super),
    .rom_dis_in (rom_dis_in),
    .ram_cs     (ram_cs),
    .io_cs      (io_cs),
    .rom_cs     (rom_cs),
    .priv_cs    (priv_cs),
    .pt_rd      (pt_rd),
    .pt_wr      (pt_wr),
    .phys_page  (phys_page)
);

// File: tb/mmu_pager_tb.sv
module mmu_pager_tb;
    localparam int PID_W = 6;
    localparam int PPN_W = 8;
    localparam int IDX_W = PID_W + 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      cpu_addr = '0;
    logic             cpu_rwb = 1'b1;
    logic             cpu_super = 1'b1;
    logic [PID_W-1:0] pid = '0;
    logic             rom_dis_in = 1'b1;
    logic [PPN_W-1:0] cpu_wdata = '0;
    logic             ram_cs, io_cs, rom_cs, priv_cs, pt_rd, pt_wr;
    logic [PPN_W-1:0] phys_page, pt_rdata;
    logic [11:0]      page_off;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    logic [PPN_W-1:0] model [1 << IDX_W];
    logic             romq = 1'b0;

    always #4 clk = ~clk;

    mmu_pager #(.PID_W(PID_W), .PPN_W(PPN_W)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rwb(cpu_rwb),
        .cpu_super(cpu_super), .pid(pid), .rom_dis_in(rom_dis_in),
        .cpu_wdata(cpu_wdata), .ram_cs(ram_cs), .io_cs(io_cs),
        .rom_cs(rom_cs), .priv_cs(priv_cs), .pt_rd(pt_rd), .pt_wr(pt_wr),
        .phys_page(phys_page), .page_off(page_off), .pt_rdata(pt_rdata)
    );

    // order {ram, io, rom, priv, ptrd, ptwr}
    function automatic logic [5:0] exp_sel(logic [15:0] a, logic rwb, logic sup, logic rd);
        if (!sup || !a[15])              return 6'b100000;
        if (a[14:10] == 5'b00001)        return 6'b010000;
        if (rwb && !rd)                  return 6'b001000;
        if (a[11:10] == 2'b00)           return rwb ? 6'b000010 : 6'b000001;
        return 6'b000100;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic rwb, input logic sup,
                         input logic [PID_W-1:0] p, input logic [PPN_W-1:0] wd);
        @(negedge clk);
        cpu_addr = a; cpu_rwb = rwb; cpu_super = sup; pid = p; cpu_wdata = wd;
        #2;
    endtask

    function automatic logic [5:0] sels();
        return {ram_cs, io_cs, rom_cs, priv_cs, pt_rd, pt_wr};
    endfunction

    // check one access against the model; record pagetable writes
    task automatic access(input string tag, input logic [15:0] a, input logic rwb,
                          input logic sup, input logic [PID_W-1:0] p, input logic [PPN_W-1:0] wd);
        logic [5:0] es;
        apply(a, rwb, sup, p, wd);
        es = exp_sel(a, rwb, sup, romq);
        chk({tag, " R10 select"}, {26'd0, sels()}, {26'd0, es});
        if (es[5]) begin
            chk({tag, " R1 phys"}, {24'd0, phys_page}, {24'd0, model[{p, rwb, a[15:12]}]});
            chk({tag, " R1 offset"}, {20'd0, page_off}, {20'd0, a[11:0]});
        end else begin
            chk({tag, " R12 phys idle"}, {24'd0, phys_page}, 32'd0);
        end
        if (es[1]) chk({tag, " R6 pt read"}, {24'd0, pt_rdata}, {24'd0, model[{p, a[4:0]}]});
        else       chk({tag, " R12 rdata idle"}, {24'd0, pt_rdata}, 32'd0);
        if (es[0]) model[{p, a[4:0]}] = wd;
    endtask

    // direct pagetable address with random segment and ignored bits
    function automatic logic [15:0] pt_addr(logic dir, logic [3:0] pg);
        logic [15:0] a;
        a = 16'h8000 | (16'($urandom_range(0, 7)) << 12) | (16'($urandom_range(0, 31)) << 5);
        a[4] = dir; a[3:0] = pg;
        if (a[14:10] == 5'b00001) a[10] = 1'b0;
        return a;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'd7731));
        // R9 reset clears ROM-disable although the input is high
        repeat (3) @(posedge clk);
        apply(16'hF000, 1'b1, 1'b1, '0, '0);
        chk("R9 reset state rom", {31'd0, rom_cs}, 32'd1);
        @(negedge clk); rst = 1'b0; rom_dis_in = 1'b0;
        @(posedge clk); romq = 1'b0;

        // R8 fill pagetable in boot mode, writes reach pagetable
        for (int p = 0; p < 6; p++)
            for (int d = 0; d < 2; d++)
                for (int g = 0; g < 16; g++) begin
                    logic [PPN_W-1:0] v;
                    v = PPN_W'($urandom);
                    a = pt_addr(d[0], g[3:0]);
                    access("R8 boot write", a, 1'b0, 1'b1, PID_W'(p), v);
                    chk("R8 write to pt", {31'd0, pt_wr}, 32'd1);
                end

        // R8 boot read of upper half is ROM, I/O still I/O
        access("R8 rom read", 16'h9123, 1'b1, 1'b1, 6'd1, 8'h00);
        chk("R8 rom_cs", {31'd0, rom_cs}, 32'd1);
        access("R5 io in boot", 16'h8400, 1'b1, 1'b1, 6'd1, 8'h00);
        chk("R5 io_cs", {31'd0, io_cs}, 32'd1);

        // R9 enable takes effect one edge later
        @(negedge clk);
        rom_dis_in = 1'b1; cpu_addr = 16'hF000; cpu_rwb = 1'b1; cpu_super = 1'b1; #2;
        chk("R9 before edge rom", {31'd0, rom_cs}, 32'd1);
        @(posedge clk); romq = 1'b1; #2;
        chk("R9 after edge pt_rd", {31'd0, pt_rd}, 32'd1);

        // R6 readback through direct access, ignored bits randomised
        for (int g = 0; g < 16; g++) begin
            a = pt_addr(g[0], g[3:0]);
            access("R6 readback", a, 1'b1, 1'b1, 6'd2, 8'h00);
            chk("R6 pt_rd", {31'd0, pt_rd}, 32'd1);
        end

        // R4 R5 R7 boundaries
        access("R4 edge", 16'h7FFF, 1'b1, 1'b1, 6'd0, 8'h00);
        chk("R4 ram_cs", {31'd0, ram_cs}, 32'd1);
        access("R6 edge", 16'h83FF, 1'b1, 1'b1, 6'd0, 8'h00);
        access("R5 low", 16'h8400, 1'b0, 1'b1, 6'd0, 8'h5A);
        chk("R5 io write", {31'd0, io_cs}, 32'd1);
        access("R5 high", 16'h87FF, 1'b1, 1'b1, 6'd0, 8'h00);
        access("R7 edge", 16'h8800, 1'b1, 1'b1, 6'd0, 8'h00);
        chk("R7 priv_cs", {31'd0, priv_cs}, 32'd1);
        access("R7 gap", 16'hFC00, 1'b0, 1'b1, 6'd0, 8'h11);
        access("R3 user io addr", 16'h8400, 1'b1, 1'b0, 6'd0, 8'h00);
        chk("R3 ram_cs", {31'd0, ram_cs}, 32'd1);

        // R2 read-only page and R11 aliasing for process 5
        access("R2 map rd", 16'h8012, 1'b0, 1'b1, 6'd5, 8'h40);
        access("R2 map wr", 16'h8002, 1'b0, 1'b1, 6'd5, 8'h41);
        access("R11 alias", 16'h8017, 1'b0, 1'b1, 6'd5, 8'h40);
        access("R2 read page2", 16'h2ABC, 1'b1, 1'b0, 6'd5, 8'h00);
        chk("R2 read phys", {24'd0, phys_page}, 32'h40);
        access("R2 write page2", 16'h2ABC, 1'b0, 1'b0, 6'd5, 8'h99);
        chk("R2 write phys", {24'd0, phys_page}, 32'h41);
        access("R11 read page7", 16'h7001, 1'b1, 1'b0, 6'd5, 8'h00);
        chk("R11 same phys", {24'd0, phys_page}, 32'h40);

        // random mix with ROM unmapped
        for (int i = 0; i < 400; i++) begin
            a = 16'($urandom);
            access("R1 random", a, 1'($urandom), 1'($urandom), PID_W'($urandom_range(0, 5)),
                   PPN_W'($urandom));
        end

        // random mix with ROM mapped again
        @(negedge clk); rom_dis_in = 1'b0;
        @(posedge clk); romq = 1'b0;
        for (int i = 0; i < 400; i++) begin
            a = 16'($urandom);
            access("R8 random", a, 1'($urandom), 1'($urandom), PID_W'($urandom_range(0, 5)),
                   PPN_W'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule